// File: doc/BRIEF.md
# Dual-Issue Packet Hazard Checker

This block is the issue stage of a statically scheduled, in-order pipeline with two slots. Each cycle it may take one 64-bit packet from fetch. The packet holds two 32-bit instructions from a small register-register subset. The lower word is the arithmetic/branch slot and the upper word is the memory slot. The block decodes both words and checks that each one suits its slot. It then hands the instructions to the two execute lanes as valid, class and instruction signals.

Scheduling is left to the compiler, so the block only enforces the hazards that forwarding cannot hide. The first is an arithmetic result that feeds the memory slot of the same packet. The block handles this by splitting the packet: it issues the first slot alone and the second slot one cycle later. The second is a load whose result is read by the very next issue. The block handles this by holding the whole packet for one cycle.

A controller with three named states drives the sequence:
- `ST_ACCEPT` takes packets from fetch.
- `ST_WAIT_LOAD` replays a packet held for the load latency.
- `ST_SPLIT_TAIL` issues the held memory slot.

The transitions are:
- accept → accept for an independent packet, an illegal packet, or no packet.
- accept → wait-load on a load-use hazard.
- accept → split-tail, and wait-load → split-tail, on a dependence inside the packet.
- wait-load → accept for an independent replay.
- split-tail → accept, always.

A downstream freeze input holds every state and output register.

Top module: `dual_issue_checker`

## Requirements
- R1: While reset is low and after it is released, fetch_ready is 1 and ex0_valid, ex1_valid, ex0_hold, ex1_hold and bad_packet are 0.
- R2: Decode rules. An all-zero word is a nop. The opcode is bits 31:26, rs is 25:21, rt is 20:16 and rd is 15:11. Opcode 0x00 is an arithmetic op that reads rs and rt and writes rd. Opcodes 0x08, 0x09, 0x0A, 0x0C and 0x0D are immediate arithmetic ops that read rs and write rt. Opcodes 0x04 and 0x05 are branches that read rs and rt. Opcode 0x23 is a load that reads rs and writes rt. Opcode 0x2B is a store that reads rs and rt. Any other opcode is illegal.
- R3: The low word (bits 31:0) may hold only a nop, an arithmetic op or a branch. The high word (bits 63:32) may hold only a nop, a load or a store. A packet that breaks this rule issues nothing. bad_packet becomes 1 at that edge and stays 1 until reset.
- R4: An accepted packet with no hazard issues both slots at the edge that accepts it. Class codes are nop=0, arithmetic=1, branch=2, load=3, store=4. A non-nop slot drives valid=1 with its class and its word. A nop slot drives valid=0, class 0 and word 0.
- R5: If the high word reads a register that the low word writes, only the low word issues and ex1_hold is 1. fetch_ready is 0 for one cycle. The high word issues alone at the next edge, with ex0_valid=0.
- R6: If both words write the same register, the packet is split exactly as in R5.
- R7: If the previous edge issued a load that writes register r, and r is not 0, a packet in which either word reads r issues nothing. At that edge ex0_hold and ex1_hold are 1 and fetch_ready drops. The packet issues at the next edge.
- R8: A load issued as the second half of a split also triggers R7 for the next packet.
- R9: Register 0 and nop words never create a split or a load-use stall.
- R10: While ds_freeze is 1, fetch_ready is 0, and every output and internal state keeps its value across the edge.
- R11: An edge in ST_ACCEPT with fetch_valid low issues nothing and clears both holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| fetch_valid | input | 1 | A packet is offered on fetch_packet |
| fetch_packet | input | 64 | Low word is the arithmetic/branch slot; high word is the memory slot |
| fetch_ready | output | 1 | The offered packet is taken at this edge |
| ds_freeze | input | 1 | Downstream stall; holds the whole stage |
| ex0_valid | output | 1 | Arithmetic/branch lane has an instruction |
| ex0_class | output | 3 | Class code of the lane 0 instruction |
| ex0_instr | output | 32 | Instruction word for lane 0 |
| ex0_hold | output | 1 | Lane 0 was held this cycle (load-use) |
| ex1_valid | output | 1 | Memory lane has an instruction |
| ex1_class | output | 3 | Class code of the lane 1 instruction |
| ex1_instr | output | 32 | Instruction word for lane 1 |
| ex1_hold | output | 1 | Lane 1 was held this cycle (split or load-use) |
| bad_packet | output | 1 | Sticky flag for a packet that broke the slot rule |

## Verification
Every lane output is a register. An independent packet therefore shows up right after the rising edge at which it is offered with fetch_ready high. A split shows its high word one edge later. A load-use replay issues one edge after the stalled edge. bad_packet rises at the same edge that drops the packet. fetch_ready is combinational from the state and the freeze input, so it reflects the new state as soon as an edge has passed. The bench changes its inputs on falling edges and samples one nanosecond after each rising edge. It steps one cycle at a time and checks each expected result in the exact cycle in which it is due.

// File: rtl/dic_pkg.sv
`timescale 1ns/1ps
package dic_pkg;
    localparam int INSTR_W = 32;
    localparam int REG_W   = 5;
    localparam int SLOTS   = 2;
    localparam int PKT_W   = INSTR_W * SLOTS;
    localparam int OPC_W   = 6;
    localparam int CLS_W   = 3;
    localparam int OPC_LSB = INSTR_W - OPC_W;
    localparam int RS_LSB  = OPC_LSB - REG_W;
    localparam int RT_LSB  = RS_LSB - REG_W;
    localparam int RD_LSB  = RT_LSB - REG_W;

    localparam logic [OPC_W-1:0] OP_REG   = 6'h00;
    localparam logic [OPC_W-1:0] OP_BEQ   = 6'h04;
    localparam logic [OPC_W-1:0] OP_BNE   = 6'h05;
    localparam logic [OPC_W-1:0] OP_ADDI  = 6'h08;
    localparam logic [OPC_W-1:0] OP_ADDIU = 6'h09;
    localparam logic [OPC_W-1:0] OP_SLTI  = 6'h0A;
    localparam logic [OPC_W-1:0] OP_ANDI  = 6'h0C;
    localparam logic [OPC_W-1:0] OP_ORI   = 6'h0D;
    localparam logic [OPC_W-1:0] OP_LOAD  = 6'h23;
    localparam logic [OPC_W-1:0] OP_STORE = 6'h2B;

    typedef enum logic [CLS_W-1:0] {
        CLS_NOP    = 3'd0,
        CLS_ALU    = 3'd1,
        CLS_BRANCH = 3'd2,
        CLS_LOAD   = 3'd3,
        CLS_STORE  = 3'd4,
        CLS_BAD    = 3'd7
    } op_class_e;

    typedef struct packed {
        op_class_e        cls;
        logic             rd_a_en;
        logic [REG_W-1:0] rd_a;
        logic             rd_b_en;
        logic [REG_W-1:0] rd_b;
        logic             wr_en;
        logic [REG_W-1:0] wr;
    } slot_dec_t;

    typedef enum logic [1:0] {
        ST_ACCEPT     = 2'd0,
        ST_WAIT_LOAD  = 2'd1,
        ST_SPLIT_TAIL = 2'd2
    } iss_state_e;
endpackage

// File: rtl/dic_slot_decode.sv
`timescale 1ns/1ps
module dic_slot_decode
    import dic_pkg::*;
(
    input  logic [INSTR_W-1:0] instr,
    output slot_dec_t          dec
);
    logic [OPC_W-1:0] opc;
    logic [REG_W-1:0] rs, rt, rd;

    always_comb begin
        opc = instr[OPC_LSB +: OPC_W];
        rs  = instr[RS_LSB +: REG_W];
        rt  = instr[RT_LSB +: REG_W];
        rd  = instr[RD_LSB +: REG_W];
        dec = '0;
        dec.cls = CLS_NOP;
        if (instr != '0) begin
            case (opc)
                OP_REG: begin
                    dec.cls  = CLS_ALU;
                    dec.rd_a = rs;  dec.rd_a_en = (rs != '0);
                    dec.rd_b = rt;  dec.rd_b_en = (rt != '0);
                    dec.wr   = rd;  dec.wr_en   = (rd != '0);
                end
                OP_ADDI, OP_ADDIU, OP_SLTI, OP_ANDI, OP_ORI: begin
                    dec.cls  = CLS_ALU;
                    dec.rd_a = rs;  dec.rd_a_en = (rs != '0);
                    dec.wr   = rt;  dec.wr_en   = (rt != '0);
                end
                OP_BEQ, OP_BNE: begin
                    dec.cls  = CLS_BRANCH;
                    dec.rd_a = rs;  dec.rd_a_en = (rs != '0);
                    dec.rd_b = rt;  dec.rd_b_en = (rt != '0);
                end
                OP_LOAD: begin
                    dec.cls  = CLS_LOAD;
                    dec.rd_a = rs;  dec.rd_a_en = (rs != '0);
                    dec.wr   = rt;  dec.wr_en   = (rt != '0);
                end
                OP_STORE: begin
                    dec.cls  = CLS_STORE;
                    dec.rd_a = rs;  dec.rd_a_en = (rs != '0);
                    dec.rd_b = rt;  dec.rd_b_en = (rt != '0);
                end
                default: dec.cls = CLS_BAD;
            endcase
        end
    end
endmodule

// File: rtl/dic_hazard_detect.sv
`timescale 1ns/1ps
module dic_hazard_detect
    import dic_pkg::*;
(
    input  slot_dec_t [SLOTS-1:0] dec,
    input  logic                  last_ld_vld,
    input  logic [REG_W-1:0]      last_ld_dst,
    output logic                  pkt_bad,
    output logic                  pair_dep,
    output logic                  load_use
);
    logic [SLOTS-1:0] slot_ok;
    logic [SLOTS-1:0] reads_ld;

    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
        if (g == 0) begin : g_alu_slot
            assign slot_ok[g] = (dec[g].cls == CLS_NOP) || (dec[g].cls == CLS_ALU) ||
                                (dec[g].cls == CLS_BRANCH);
        end else begin : g_mem_slot
            assign slot_ok[g] = (dec[g].cls == CLS_NOP) || (dec[g].cls == CLS_LOAD) ||
                                (dec[g].cls == CLS_STORE);
        end
        assign reads_ld[g] = (dec[g].rd_a_en && (dec[g].rd_a == last_ld_dst)) ||
                             (dec[g].rd_b_en && (dec[g].rd_b == last_ld_dst));
    end

    always_comb begin
        pkt_bad  = ~&slot_ok;
        load_use = last_ld_vld && (|reads_ld);
        pair_dep = dec[0].wr_en &&
                   ((dec[1].rd_a_en && (dec[1].rd_a == dec[0].wr)) ||
                    (dec[1].rd_b_en && (dec[1].rd_b == dec[0].wr)) ||
                    (dec[1].wr_en   && (dec[1].wr   == dec[0].wr)));
    end
endmodule

// File: rtl/dic_issue_fsm.sv
`timescale 1ns/1ps
module dic_issue_fsm
    import dic_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               fetch_valid,
    input  logic [PKT_W-1:0]   fetch_packet,
    input  logic               ds_freeze,
    input  op_class_e          cls0,
    input  op_class_e          cls1,
    input  logic               tail_wr_en,
    input  logic [REG_W-1:0]   tail_wr,
    input  logic               pkt_bad,
    input  logic               pair_dep,
    input  logic               load_use,
    output logic [PKT_W-1:0]   cur_pkt,
    output logic               fetch_ready,
    output logic               last_ld_vld,
    output logic [REG_W-1:0]   last_ld_dst,
    output logic               ex0_valid,
    output logic [CLS_W-1:0]   ex0_class,
    output logic [INSTR_W-1:0] ex0_instr,
    output logic               ex0_hold,
    output logic               ex1_valid,
    output logic [CLS_W-1:0]   ex1_class,
    output logic [INSTR_W-1:0] ex1_instr,
    output logic               ex1_hold,
    output logic               bad_packet
);
    iss_state_e       state_q, state_d;
    logic [PKT_W-1:0] hold_q;
    logic             have_pkt;
    logic             iss0, iss1, stall0, stall1, keep_pkt, flag_bad;

    always_comb begin
        cur_pkt     = (state_q == ST_ACCEPT) ? fetch_packet : hold_q;
        have_pkt    = (state_q == ST_ACCEPT) ? fetch_valid : 1'b1;
        fetch_ready = (state_q == ST_ACCEPT) && !ds_freeze;
        state_d  = state_q;
        iss0     = 1'b0;
        iss1     = 1'b0;
        stall0   = 1'b0;
        stall1   = 1'b0;
        keep_pkt = 1'b0;
        flag_bad = 1'b0;
        unique case (state_q)
            ST_ACCEPT, ST_WAIT_LOAD: begin
                if (have_pkt) begin
                    if (pkt_bad) begin
                        flag_bad = 1'b1;
                        state_d  = ST_ACCEPT;
                    end else if (load_use) begin
                        stall0   = 1'b1;
                        stall1   = 1'b1;
                        keep_pkt = 1'b1;
                        state_d  = ST_WAIT_LOAD;
                    end else if (pair_dep) begin
                        iss0     = 1'b1;
                        stall1   = 1'b1;
                        keep_pkt = 1'b1;
                        state_d  = ST_SPLIT_TAIL;
                    end else begin
                        iss0    = 1'b1;
                        iss1    = 1'b1;
                        state_d = ST_ACCEPT;
                    end
                end
            end
            ST_SPLIT_TAIL: begin
                iss1    = 1'b1;
                state_d = ST_ACCEPT;
            end
            default: state_d = ST_ACCEPT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_ACCEPT;
            hold_q  <= '0;
        end else if (!ds_freeze) begin
            state_q <= state_d;
            if (keep_pkt) hold_q <= cur_pkt;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ex0_valid   <= 1'b0;
            ex0_class   <= CLS_NOP;
            ex0_instr   <= '0;
            ex0_hold    <= 1'b0;
            ex1_valid   <= 1'b0;
            ex1_class   <= CLS_NOP;
            ex1_instr   <= '0;
            ex1_hold    <= 1'b0;
            bad_packet  <= 1'b0;
            last_ld_vld <= 1'b0;
            last_ld_dst <= '0;
        end else if (!ds_freeze) begin
            ex0_valid   <= iss0 && (cls0 != CLS_NOP);
            ex0_class   <= iss0 ? cls0 : CLS_NOP;
            ex0_instr   <= iss0 ? cur_pkt[0 +: INSTR_W] : '0;
            ex0_hold    <= stall0;
            ex1_valid   <= iss1 && (cls1 != CLS_NOP);
            ex1_class   <= iss1 ? cls1 : CLS_NOP;
            ex1_instr   <= iss1 ? cur_pkt[INSTR_W +: INSTR_W] : '0;
            ex1_hold    <= stall1;
            bad_packet  <= bad_packet | flag_bad;
            last_ld_vld <= iss1 && (cls1 == CLS_LOAD) && tail_wr_en;
            last_ld_dst <= tail_wr;
        end
    end
endmodule

// File: rtl/dual_issue_checker.sv
`timescale 1ns/1ps
module dual_issue_checker
    import dic_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               fetch_valid,
    input  logic [PKT_W-1:0]   fetch_packet,
    output logic               fetch_ready,
    input  logic               ds_freeze,
    output logic               ex0_valid,
    output logic [CLS_W-1:0]   ex0_class,
    output logic [INSTR_W-1:0] ex0_instr,
    output logic               ex0_hold,
    output logic               ex1_valid,
    output logic [CLS_W-1:0]   ex1_class,
    output logic [INSTR_W-1:0] ex1_instr,
    output logic               ex1_hold,
    output logic               bad_packet
);
    logic [PKT_W-1:0]      cur_pkt;
    slot_dec_t [SLOTS-1:0] dec;
    logic                  pkt_bad, pair_dep, load_use;
    logic                  last_ld_vld;
    logic [REG_W-1:0]      last_ld_dst;

    for (genvar g = 0; g < SLOTS; g++) begin : g_dec
        dic_slot_decode u_dec (
            .instr (cur_pkt[g*INSTR_W +: INSTR_W]),
            .dec   (dec[g])
        );
    end

    dic_hazard_detect u_haz (
        .dec         (dec),
        .last_ld_vld (last_ld_vld),
        .last_ld_dst (last_ld_dst),
        .pkt_bad     (pkt_bad),
        .pair_dep    (pair_dep),
        .load_use    (load_use)
    );

    dic_issue_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .fetch_valid  (fetch_valid),
        .fetch_packet (fetch_packet),
        .ds_freeze    (ds_freeze),
        .cls0         (dec[0].cls),
        .cls1         (dec[1].cls),
        .tail_wr_en   (dec[1].wr_en),
        .tail_wr      (dec[1].wr),
        .pkt_bad      (pkt_bad),
        .pair_dep     (pair_dep),
        .load_use     (load_use),
        .cur_pkt      (cur_pkt),
        .fetch_ready  (fetch_ready),
        .last_ld_vld  (last_ld_vld),
        .last_ld_dst  (last_ld_dst),
        .ex0_valid    (ex0_valid),
        .ex0_class    (ex0_class),
        .ex0_instr    (ex0_instr),
        .ex0_hold     (ex0_hold),
        .ex1_valid    (ex1_valid),
        .ex1_class    (ex1_class),
        .ex1_instr    (ex1_instr),
        .ex1_hold     (ex1_hold),
        .bad_packet   (bad_packet)
    );
endmodule

// File: rtl/dic_issue_checker.sv
`timescale 1ns/1ps
module dic_issue_checker
    import dic_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               ds_freeze,
    input logic               fetch_ready,
    input logic               ex0_valid,
    input logic [CLS_W-1:0]   ex0_class,
    input logic [INSTR_W-1:0] ex0_instr,
    input logic               ex0_hold,
    input logic               ex1_valid,
    input logic [CLS_W-1:0]   ex1_class,
    input logic [INSTR_W-1:0] ex1_instr,
    input logic               ex1_hold,
    input logic               bad_packet
);
    assert_ex0_class_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ex0_valid |-> (ex0_class == 3'd1 || ex0_class == 3'd2));

    assert_ex1_class_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ex1_valid |-> (ex1_class == 3'd3 || ex1_class == 3'd4));

    assert_bad_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
        bad_packet |=> bad_packet);

    assert_split_tail_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ex1_hold && !ex0_hold && !ds_freeze) |=> (!ex0_valid && ex1_valid && !ex1_hold));

    assert_fetch_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ex1_hold |-> !fetch_ready);

    assert_load_stall_once_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ex0_hold && !ds_freeze) |=> !ex0_hold);

    assert_hold_pair_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ex0_hold |-> ex1_hold);

    assert_freeze_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ds_freeze |=> ($stable(ex0_valid) && $stable(ex1_valid) && $stable(ex0_instr) &&
                       $stable(ex1_instr) && $stable(ex1_hold) && $stable(bad_packet)));
endmodule

bind dual_issue_checker dic_issue_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ds_freeze   (ds_freeze),
    .fetch_ready (fetch_ready),
    .ex0_valid   (ex0_valid),
    .ex0_class   (ex0_class),
    .ex0_instr   (ex0_instr),
    .ex0_hold    (ex0_hold),
    .ex1_valid   (ex1_valid),
    .ex1_class   (ex1_class),
    .ex1_instr   (ex1_instr),
    .ex1_hold    (ex1_hold),
    .bad_packet  (bad_packet)
);

// File: tb/dual_issue_checker_tb_top.sv
`timescale 1ns/1ps
module dual_issue_checker_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fetch_valid = 1'b0;
    logic [63:0] fetch_packet = '0;
    logic        ds_freeze = 1'b0;
    logic        fetch_ready;
    logic        ex0_valid, ex0_hold, ex1_valid, ex1_hold, bad_packet;
    logic [2:0]  ex0_class, ex1_class;
    logic [31:0] ex0_instr, ex1_instr;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    dual_issue_checker dut_i (
        .clk(clk), .rst_n(rst_n), .fetch_valid(fetch_valid), .fetch_packet(fetch_packet),
        .fetch_ready(fetch_ready), .ds_freeze(ds_freeze),
        .ex0_valid(ex0_valid), .ex0_class(ex0_class), .ex0_instr(ex0_instr), .ex0_hold(ex0_hold),
        .ex1_valid(ex1_valid), .ex1_class(ex1_class), .ex1_instr(ex1_instr), .ex1_hold(ex1_hold),
        .bad_packet(bad_packet)
    );

    localparam logic [31:0] NOP = 32'h0;

    function automatic logic [31:0] op_add(input logic [4:0] rd, input logic [4:0] rs, input logic [4:0] rt);
        return {6'h00, rs, rt, rd, 5'd0, 6'h20};
    endfunction
    function automatic logic [31:0] op_addi(input logic [4:0] rt, input logic [4:0] rs);
        return {6'h08, rs, rt, 16'h0005};
    endfunction
    function automatic logic [31:0] op_beq(input logic [4:0] rs, input logic [4:0] rt);
        return {6'h04, rs, rt, 16'h0010};
    endfunction
    function automatic logic [31:0] op_lw(input logic [4:0] rt, input logic [4:0] base);
        return {6'h23, base, rt, 16'h0000};
    endfunction
    function automatic logic [31:0] op_sw(input logic [4:0] rt, input logic [4:0] base);
        return {6'h2B, base, rt, 16'h0004};
    endfunction
    function automatic logic [63:0] pk(input logic [31:0] mem_w, input logic [31:0] alu_w);
        return {mem_w, alu_w};
    endfunction

    task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic chk_issue(input string req,
                             input logic v0, input logic [2:0] c0, input logic [31:0] i0,
                             input logic v1, input logic [2:0] c1, input logic [31:0] i1,
                             input logic h0, input logic h1, input logic rdy);
        chk(req, "ex0_valid", 64'(ex0_valid), 64'(v0));
        chk(req, "ex0_class", 64'(ex0_class), 64'(c0));
        chk(req, "ex0_instr", 64'(ex0_instr), 64'(i0));
        chk(req, "ex1_valid", 64'(ex1_valid), 64'(v1));
        chk(req, "ex1_class", 64'(ex1_class), 64'(c1));
        chk(req, "ex1_instr", 64'(ex1_instr), 64'(i1));
        chk(req, "ex0_hold", 64'(ex0_hold), 64'(h0));
        chk(req, "ex1_hold", 64'(ex1_hold), 64'(h1));
        chk(req, "fetch_ready", 64'(fetch_ready), 64'(rdy));
    endtask

    task automatic cyc(input logic v, input logic [63:0] d, input logic frz);
        @(negedge clk);
        fetch_valid = v;
        fetch_packet = d;
        ds_freeze = frz;
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        fetch_valid = 1'b0;
        ds_freeze = 1'b0;
        repeat (2) @(posedge clk);
        #1;
        chk("R1", "ready in reset", 64'(fetch_ready), 64'd1);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        chk_issue("R1", 0, 0, 0, 0, 0, 0, 0, 0, 1);
        chk("R1", "bad_packet", 64'(bad_packet), 64'd0);
    endtask

    task automatic t_independent();
        cyc(1, pk(op_lw(5'd4, 5'd5), op_add(5'd3, 5'd1, 5'd2)), 0);
        chk_issue("R4", 1, 1, op_add(5'd3, 5'd1, 5'd2), 1, 3, op_lw(5'd4, 5'd5), 0, 0, 1);
        cyc(1, pk(op_sw(5'd6, 5'd2), op_beq(5'd1, 5'd2)), 0);
        chk_issue("R2", 1, 2, op_beq(5'd1, 5'd2), 1, 4, op_sw(5'd6, 5'd2), 0, 0, 1);
        cyc(1, pk(NOP, op_addi(5'd7, 5'd1)), 0);
        chk_issue("R4", 1, 1, op_addi(5'd7, 5'd1), 0, 0, 0, 0, 0, 1);
        cyc(0, pk(op_sw(5'd6, 5'd2), NOP), 0);
        chk_issue("R11", 0, 0, 0, 0, 0, 0, 0, 0, 1);
    endtask

    task automatic t_split_raw();
        cyc(1, pk(op_sw(5'd7, 5'd3), op_add(5'd3, 5'd1, 5'd2)), 0);
        chk_issue("R5", 1, 1, op_add(5'd3, 5'd1, 5'd2), 0, 0, 0, 0, 1, 0);
        cyc(1, pk(op_lw(5'd9, 5'd9), op_add(5'd9, 5'd9, 5'd9)), 0);
        chk_issue("R5", 0, 0, 0, 1, 4, op_sw(5'd7, 5'd3), 0, 0, 1);
        cyc(0, '0, 0);
    endtask

    task automatic t_split_waw();
        cyc(1, pk(op_lw(5'd4, 5'd2), op_addi(5'd4, 5'd1)), 0);
        chk_issue("R6", 1, 1, op_addi(5'd4, 5'd1), 0, 0, 0, 0, 1, 0);
        cyc(0, '0, 0);
        chk_issue("R6", 0, 0, 0, 1, 3, op_lw(5'd4, 5'd2), 0, 0, 1);
        cyc(0, '0, 0);
    endtask

    task automatic t_reg_zero();
        cyc(1, pk(op_lw(5'd6, 5'd0), op_add(5'd0, 5'd1, 5'd2)), 0);
        chk_issue("R9", 1, 1, op_add(5'd0, 5'd1, 5'd2), 1, 3, op_lw(5'd6, 5'd0), 0, 0, 1);
        cyc(1, pk(op_lw(5'd0, 5'd1), NOP), 0);
        chk_issue("R9", 0, 0, 0, 1, 3, op_lw(5'd0, 5'd1), 0, 0, 1);
        cyc(1, pk(NOP, op_add(5'd5, 5'd0, 5'd0)), 0);
        chk_issue("R9", 1, 1, op_add(5'd5, 5'd0, 5'd0), 0, 0, 0, 0, 0, 1);
        cyc(1, pk(op_sw(5'd3, 5'd3), NOP), 0);
        chk_issue("R9", 0, 0, 0, 1, 4, op_sw(5'd3, 5'd3), 0, 0, 1);
        cyc(0, '0, 0);
    endtask

    task automatic t_load_use();
        cyc(1, pk(op_lw(5'd8, 5'd1), NOP), 0);
        chk_issue("R7", 0, 0, 0, 1, 3, op_lw(5'd8, 5'd1), 0, 0, 1);
        cyc(1, pk(NOP, op_add(5'd9, 5'd8, 5'd2)), 0);
        chk_issue("R7", 0, 0, 0, 0, 0, 0, 1, 1, 0);
        cyc(0, '0, 0);
        chk_issue("R7", 1, 1, op_add(5'd9, 5'd8, 5'd2), 0, 0, 0, 0, 0, 1);
        cyc(1, pk(op_lw(5'd12, 5'd1), NOP), 0);
        cyc(1, pk(op_sw(5'd12, 5'd1), NOP), 0);
        chk_issue("R7", 0, 0, 0, 0, 0, 0, 1, 1, 0);
        cyc(0, '0, 0);
        chk_issue("R7", 0, 0, 0, 1, 4, op_sw(5'd12, 5'd1), 0, 0, 1);
        cyc(1, pk(op_lw(5'd8, 5'd1), NOP), 0);
        cyc(1, pk(NOP, op_add(5'd9, 5'd1, 5'd2)), 0);
        chk_issue("R7", 1, 1, op_add(5'd9, 5'd1, 5'd2), 0, 0, 0, 0, 0, 1);
        cyc(0, '0, 0);
    endtask

    task automatic t_tail_load();
        cyc(1, pk(op_lw(5'd10, 5'd3), op_add(5'd3, 5'd1, 5'd2)), 0);
        chk_issue("R8", 1, 1, op_add(5'd3, 5'd1, 5'd2), 0, 0, 0, 0, 1, 0);
        cyc(0, '0, 0);
        chk_issue("R8", 0, 0, 0, 1, 3, op_lw(5'd10, 5'd3), 0, 0, 1);
        cyc(1, pk(NOP, op_add(5'd11, 5'd10, 5'd1)), 0);
        chk_issue("R8", 0, 0, 0, 0, 0, 0, 1, 1, 0);
        cyc(0, '0, 0);
        chk_issue("R8", 1, 1, op_add(5'd11, 5'd10, 5'd1), 0, 0, 0, 0, 0, 1);
        cyc(0, '0, 0);
    endtask

    task automatic t_freeze();
        cyc(1, pk(op_lw(5'd4, 5'd5), op_add(5'd3, 5'd1, 5'd2)), 0);
        cyc(1, pk(op_sw(5'd6, 5'd2), op_beq(5'd1, 5'd2)), 1);
        chk_issue("R10", 1, 1, op_add(5'd3, 5'd1, 5'd2), 1, 3, op_lw(5'd4, 5'd5), 0, 0, 0);
        cyc(1, pk(op_sw(5'd6, 5'd2), op_beq(5'd1, 5'd2)), 0);
        chk_issue("R10", 1, 2, op_beq(5'd1, 5'd2), 1, 4, op_sw(5'd6, 5'd2), 0, 0, 1);
        cyc(1, pk(op_sw(5'd7, 5'd3), op_add(5'd3, 5'd1, 5'd2)), 0);
        cyc(0, '0, 1);
        chk_issue("R10", 1, 1, op_add(5'd3, 5'd1, 5'd2), 0, 0, 0, 0, 1, 0);
        cyc(0, '0, 0);
        chk_issue("R10", 0, 0, 0, 1, 4, op_sw(5'd7, 5'd3), 0, 0, 1);
        cyc(0, '0, 0);
    endtask

    task automatic t_illegal();
        cyc(1, pk(op_add(5'd1, 5'd2, 5'd3), NOP), 0);
        chk_issue("R3", 0, 0, 0, 0, 0, 0, 0, 0, 1);
        chk("R3", "bad_packet set", 64'(bad_packet), 64'd1);
        cyc(1, pk(op_lw(5'd4, 5'd5), op_add(5'd3, 5'd1, 5'd2)), 0);
        chk_issue("R3", 1, 1, op_add(5'd3, 5'd1, 5'd2), 1, 3, op_lw(5'd4, 5'd5), 0, 0, 1);
        chk("R3", "bad_packet sticky", 64'(bad_packet), 64'd1);
        do_reset();
        cyc(1, pk(NOP, op_lw(5'd2, 5'd1)), 0);
        chk_issue("R3", 0, 0, 0, 0, 0, 0, 0, 0, 1);
        chk("R3", "load in low word", 64'(bad_packet), 64'd1);
        do_reset();
        cyc(1, pk(NOP, {6'h3F, 26'h0000123}), 0);
        chk_issue("R2", 0, 0, 0, 0, 0, 0, 0, 0, 1);
        chk("R2", "unknown opcode", 64'(bad_packet), 64'd1);
        do_reset();
    endtask

    initial begin
        do_reset();
        t_independent();
        t_split_raw();
        t_split_waw();
        t_reg_zero();
        t_load_use();
        t_tail_load();
        t_freeze();
        t_illegal();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule